// File: doc/BRIEF.md
# Gated 13-bit timer/counter

This block is a 13-bit up-counter that advances on one of three tick sources: falling edges on an external count pin, every cycle of the system clock, or a free-running prescaled clock at one of four division ratios. Counting is enabled by a run bit. It can also be made to depend on an external gate input whose active level is selectable. With that gating on, the gate signal alone starts and stops the count, so the count measures the gate pulse width in ticks.

Software reaches the block through a simple register port. Writes take one cycle and reads are combinational. Software loads the count as a 5-bit low part and an 8-bit high part before it enables counting, and it reads both parts back. When the count wraps past its maximum, a sticky overflow flag is set. Both asynchronous inputs pass through two-flop synchronizers before the block uses them.

Top module: `gated_timer13`

## Requirements
- R1: After reset the count is 0, every control field reads 0 and the overflow flag is 0.
- R2: Address 0 holds count bits 4:0 in data bits 4:0, plus three spare bits in data bits 7:5. The spare bits read back as last written and are never changed by counting. Address 1 holds count bits 12:5. Address 2 is control: bit 0 run, bit 1 gate enable, bit 2 pin mode, bit 3 system-clock tick, bits 5:4 scale, bit 6 gate polarity, bit 7 overflow flag. Address 3 reads 0.
- R3: With pin mode 0, system-clock tick 1, run 1 and gate enable 0, the count increments on every clock cycle.
- R4: With pin mode 0 and system-clock tick 0, the tick is the system clock divided by 12, 4, 48 or 8 for scale 00, 01, 10 or 11. Over any 48 consecutive enabled cycles the count advances by exactly 48 divided by that ratio.
- R5: With pin mode 1, each high-to-low transition of the count pin adds exactly one to the count. The increment appears on the third rising clock edge after the pin falls. Rising transitions add nothing.
- R6: With run 0 the count holds. Setting run does not clear the count.
- R7: With gate enable 1, counting proceeds only while the gate input XOR the polarity bit equals 1.
- R8: A wrap from 0x1FFF to 0x0000 sets the overflow flag. The flag stays set until a control write with bit 7 equal to 0. A control write with bit 7 equal to 1 leaves the flag unchanged.
- R9: A write to either count byte takes priority over an increment in the same cycle, so no increment occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| gate_i | input | 1 | External gate input, asynchronous |
| ovf_o | output | 1 | Sticky overflow flag |
| count_o | output | 13 | Current 13-bit count |

## Verification
The count is visible at the ports on every cycle. A wrong tick selection or wrong gating therefore shows as a wrong total after a window of known length, at the first sample after that window closes. A bad prescaler phase or divisor shows only over a full 48-cycle window, which is why the prescale windows are exactly that long. Faults in the synchronizer or edge detector show as a one-cycle shift in when a pin edge lands, or as a double count. A lost write priority shows in the very next cycle as a low byte one higher than the value written.

// File: rtl/t13_pkg.sv
package t13_pkg;
  localparam int unsigned LO_W = 5;
  localparam int unsigned HI_W = 8;
  localparam int unsigned CNT_W = LO_W + HI_W;
  localparam int unsigned SPARE_W = 8 - LO_W;

  typedef enum logic [1:0] {
    A_LO   = 2'd0,
    A_HI   = 2'd1,
    A_CTRL = 2'd2,
    A_NONE = 2'd3
  } t13_addr_e;

  typedef struct packed {
    logic       ovf;
    logic       gate_pol;
    logic [1:0] scale;
    logic       sys_clk;
    logic       pin_mode;
    logic       gate_en;
    logic       run;
  } t13_ctrl_t;
endpackage

// File: rtl/t13_sync.sv
module t13_sync #(
  parameter int unsigned WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/t13_prescale.sv
module t13_prescale #(
  parameter int unsigned DIV0 = 12,
  parameter int unsigned DIV1 = 4,
  parameter int unsigned DIV2 = 48,
  parameter int unsigned DIV3 = 8,
  parameter int unsigned PERIOD = 48
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] scale_i,
  output logic       tick_o
);
  localparam int unsigned CW = $clog2(PERIOD);

  function automatic int unsigned div_of(input int unsigned idx);
    case (idx)
      0:       return DIV0;
      1:       return DIV1;
      2:       return DIV2;
      default: return DIV3;
    endcase
  endfunction

  logic [CW-1:0] cnt_q;
  logic [3:0]    tick_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (cnt_q == CW'(PERIOD - 1))   cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < 4; i++) begin : g_div
    localparam int unsigned D = div_of(i);
    assign tick_vec[i] = ((32'(cnt_q) % D) == (D - 1));
  end

  assign tick_o = tick_vec[scale_i];
endmodule

// File: rtl/t13_count.sv
module t13_count
  import t13_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inc_i,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic [7:0]         wd_i,
  output logic [CNT_W-1:0]   count_o,
  output logic [SPARE_W-1:0] spare_o,
  output logic               wrap_o
);
  logic [LO_W-1:0]    lo_q;
  logic [HI_W-1:0]    hi_q;
  logic [SPARE_W-1:0] spare_q;
  logic               step;

  assign step    = inc_i & ~wr_lo_i & ~wr_hi_i;
  assign count_o = {hi_q, lo_q};
  assign wrap_o  = step & (&count_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_q    <= '0;
      spare_q <= '0;
    end else begin
      if (wr_lo_i) begin
        lo_q    <= wd_i[LO_W-1:0];
        spare_q <= wd_i[7:LO_W];
      end
      if (wr_hi_i) hi_q <= wd_i;
      if (step) {hi_q, lo_q} <= count_o + 1'b1;
    end
  end

  assign spare_o = spare_q;
endmodule

// File: rtl/gated_timer13.sv
module gated_timer13
  import t13_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [7:0]       rd_data_o,
  input  logic             cnt_pin_i,
  input  logic             gate_i,
  output logic             ovf_o,
  output logic [CNT_W-1:0] count_o
);
  t13_ctrl_t          ctrl_q;
  logic               run_q;
  logic [SPARE_W-1:0] spare_q;
  logic [1:0]         sync_w;
  logic               pin_s, gate_s, pin_prev_q, pin_fall;
  logic               presc_tick, tick, enable, wrap;
  logic               wr_lo, wr_hi, wr_ctrl;

  assign wr_lo   = wr_en_i && (wr_addr_i == A_LO);
  assign wr_hi   = wr_en_i && (wr_addr_i == A_HI);
  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);

  // bit0 = count pin (idles high), bit1 = gate
  t13_sync #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
    .clk_i, .rst_ni, .d_i({gate_i, cnt_pin_i}), .q_o(sync_w)
  );
  assign pin_s  = sync_w[0];
  assign gate_s = sync_w[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_prev_q <= 1'b1;
    else         pin_prev_q <= pin_s;
  end
  assign pin_fall = pin_prev_q & ~pin_s;

  t13_prescale u_presc (
    .clk_i, .rst_ni, .scale_i(ctrl_q.scale), .tick_o(presc_tick)
  );

  always_comb begin
    if (ctrl_q.pin_mode)     tick = pin_fall;
    else if (ctrl_q.sys_clk) tick = 1'b1;
    else                     tick = presc_tick;
  end

  assign enable = ctrl_q.run & (~ctrl_q.gate_en | (gate_s ^ ctrl_q.gate_pol));

  t13_count u_count (
    .clk_i, .rst_ni,
    .inc_i(enable & tick), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wd_i(wr_data_i),
    .count_o, .spare_o(spare_q), .wrap_o(wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else begin
      if (wr_ctrl) ctrl_q[6:0] <= wr_data_i[6:0];
      // write-0-to-clear; a wrap in the same cycle wins
      ctrl_q.ovf <= wrap | (ctrl_q.ovf & ~(wr_ctrl & ~wr_data_i[7]));
    end
  end

  assign run_q = ctrl_q.run;
  assign ovf_o = ctrl_q.ovf;

  always_comb begin
    case (rd_addr_i)
      A_LO:    rd_data_o = {spare_q, count_o[LO_W-1:0]};
      A_HI:    rd_data_o = count_o[CNT_W-1:LO_W];
      A_CTRL:  rd_data_o = ctrl_q;
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/t13_checker.sv
module t13_checker
  import t13_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [1:0]         wr_addr_i,
  input logic [7:0]         wr_data_i,
  input logic [CNT_W-1:0]   count_o,
  input logic               ovf_o,
  input logic               run_q,
  input logic [SPARE_W-1:0] spare_q
);
  // R6: stopped and unwritten count holds
  p_hold_stopped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(run_q) && !$past(wr_en_i)) |-> $stable(count_o));

  // R3/R4/R5: never more than one step per cycle
  p_single_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> (count_o == $past(count_o) || count_o == $past(count_o) + 13'd1));

  // R8: wrap raises the flag
  p_wrap_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(count_o) == 13'h1FFF && count_o == 13'h0000 && !$past(wr_en_i)) |-> ovf_o);

  // R8: flag is sticky until a clearing control write
  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ovf_o) && !($past(wr_en_i) && $past(wr_addr_i) == 2'd2 && !$past(wr_data_i[7])))
    |-> ovf_o);

  // R2: spare bits untouched except by a low-byte write
  p_spare_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($past(wr_en_i) && $past(wr_addr_i) == 2'd0) |-> $stable(spare_q));

  // R9: high-byte write lands exactly, no increment on top
  p_write_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && $past(wr_addr_i) == 2'd1) |-> count_o[CNT_W-1:LO_W] == $past(wr_data_i));
endmodule

bind gated_timer13 t13_checker chk_i (.*);

// File: tb/gated_timer13_tb_top.sv
`timescale 1ns/1ps
module gated_timer13_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        cnt_pin = 1'b1;
  logic        gate = 1'b0;
  logic        ovf;
  logic [12:0] count;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gated_timer13 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cnt_pin_i(cnt_pin), .gate_i(gate), .ovf_o(ovf), .count_o(count)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic load(input logic [12:0] v);
    wr(2'd0, {3'b000, v[4:0]});
    wr(2'd1, v[12:5]);
  endtask

  // enabled for exactly k rising edges (k >= 2)
  task automatic window(input logic [7:0] c, input int k);
    wr(2'd2, c | 8'h01);
    repeat (k - 2) @(negedge clk);
    wr(2'd2, c & 8'hFE);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 count", count, 0);
    chk("R1 ovf", ovf, 0);
    rd(2'd2, d); chk("R1 ctrl", d, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R2 low readback", d, 8'hFF);
    chk("R2 low count", count, 13'h001F);
    wr(2'd1, 8'hA5);
    rd(2'd1, d); chk("R2 high readback", d, 8'hA5);
    chk("R2 count assembled", count, {8'hA5, 5'h1F});
    rd(2'd3, d); chk("R2 unused addr", d, 0);
    wr(2'd2, 8'h7E);
    rd(2'd2, d); chk("R2 ctrl readback", d, 8'h7E);
    wr(2'd2, 8'h80);
  endtask

  task automatic t_sysclk;
    load(13'd0);
    window(8'h88, 10);
    chk("R3 sysclk count", count, 10);
    repeat (5) @(negedge clk);
    chk("R6 hold when stopped", count, 10);
    window(8'h88, 5);
    chk("R6 run keeps count", count, 15);
  endtask

  task automatic t_prescale;
    int divs[4] = '{12, 4, 48, 8};
    for (int s = 0; s < 4; s++) begin
      load(13'd0);
      window(8'h80 | 8'(s << 4), 48);
      chk($sformatf("R4 scale %0d", s), count, 48 / divs[s]);
    end
  endtask

  task automatic t_pin;
    load(13'd0);
    wr(2'd2, 8'h85);
    cnt_pin = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R5 latency early", count, 0);
    @(negedge clk);
    chk("R5 latency edge3", count, 1);
    repeat (3) @(negedge clk);
    cnt_pin = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 rising ignored", count, 1);
    for (int i = 0; i < 5; i++) begin
      cnt_pin = 1'b0; repeat (3) @(negedge clk);
      cnt_pin = 1'b1; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R5 pulse count", count, 6);
    wr(2'd2, 8'h84);
  endtask

  task automatic t_gate;
    load(13'd0);
    gate = 1'b0; repeat (4) @(negedge clk);
    window(8'h8A, 10);
    chk("R7 gate low blocks", count, 0);
    gate = 1'b1; repeat (4) @(negedge clk);
    window(8'h8A, 10);
    chk("R7 gate high counts", count, 10);
    window(8'hCA, 10);
    chk("R7 inverted blocks", count, 10);
    gate = 1'b0; repeat (4) @(negedge clk);
    window(8'hCA, 7);
    chk("R7 inverted counts", count, 17);
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    load(13'h1FFF);
    chk("R8 no flag yet", ovf, 0);
    window(8'h88, 3);
    chk("R8 wrapped count", count, 2);
    chk("R8 flag set", ovf, 1);
    wr(2'd2, 8'h88);
    chk("R8 write 1 keeps", ovf, 1);
    rd(2'd2, d); chk("R8 flag readback", d[7], 1);
    wr(2'd2, 8'h08);
    chk("R8 write 0 clears", ovf, 0);
  endtask

  task automatic t_priority;
    logic [7:0] d;
    load(13'd0);
    wr(2'd2, 8'h89);
    repeat (5) @(negedge clk);
    wr(2'd0, 8'h03);
    chk("R9 write wins", count, 3);
    @(negedge clk);
    chk("R9 resumes", count, 4);
    wr(2'd2, 8'h88);
    wr(2'd0, 8'hE0);
    wr(2'd1, 8'h00);
    window(8'h88, 40);
    rd(2'd0, d); chk("R2 spare kept", d, 8'hE8);
    chk("R2 carry to high", count, 40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_sysclk();
    t_prescale();
    t_pin();
    t_gate();
    t_wrap();
    t_priority();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule